// File: doc/BRIEF.md
# Immediate-Form Instruction Byte Decoder

This block sits behind an instruction fetch path that hands over one byte per cycle, qualified by a valid strobe. It parses instructions whose operand is a constant held in the instruction itself. Each instruction starts with an opcode byte. Some opcodes then need an addressing byte. Last comes an 8-bit or a 32-bit constant, and a 32-bit constant arrives least-significant byte first. When the final byte has been taken, the decoder raises a one-cycle strobe and presents a record for the execute stage. The record holds the instruction class, whether the operand is a register or memory named by a register, a destination register index, a sub-operation code and the assembled constant.

The decoder also rejects input it cannot handle. This covers opcodes outside the supported set, addressing bytes that would need a displacement, and sub-operation codes that the opcode does not define. It reports each rejection with a one-cycle error strobe and goes back to waiting for an opcode. Scale-index bytes and displacements are not parsed.

Top module: `imm_decoder`

## Requirements
- R1: A synchronous active-low reset clears `dec_valid` and `dec_err` and returns the parser to waiting for an opcode, including when the reset lands in the middle of an instruction.
- R2: A 32-bit constant is assembled from four bytes, least-significant first, so that the bytes 0a 0b 0c 0d yield 0x0d0c0b0a.
- R3: Opcodes 0xb8 to 0xbf take no addressing byte and take a 32-bit constant. They report class 4, register mode, sub-operation 0 and destination index equal to opcode bits [2:0].
- R4: Opcodes 0x81 (class 0) and 0xc7 (class 2) take an addressing byte and then a 32-bit constant. The addressing byte is decoded as follows: bits [7:6]=11 gives register mode (`dec_is_reg`=1), 00 gives memory mode (0), bits [5:3] give the sub-operation and bits [2:0] give the destination.
- R5: Opcode 0xc1 (class 1) takes an addressing byte, decoded as in R4, and then a single constant byte, which is zero-extended to the full width.
- R6: Opcodes 0x25, 0x0d, 0x35, 0x2d and 0x3d take only a 32-bit constant. They report class 3, register mode and destination 0 (the accumulator). The sub-operation is and=4, or=1, xor=6, subtract=5, compare=7, which are the same codes class 0 uses.
- R7: Opcode 0x68 takes only a 32-bit constant. It reports class 5, memory mode, sub-operation 0 and destination 4 (the stack pointer, which the executor lowers by 4 before it stores).
- R8: `dec_valid` is high for exactly the one cycle that follows the clock edge accepting the last byte. The record fields hold their values until the next decode completes.
- R9: An opcode outside the supported set raises `dec_err` for one cycle after its edge and produces no `dec_valid`. The next byte is parsed as an opcode.
- R10: Certain addressing bytes are rejected: mode 01 or 10 for any opcode, sub-operation 2 or 3 under 0x81, any sub-operation other than 4, 5 or 7 under 0xc1, and any non-zero sub-operation under 0xc7. A rejected addressing byte raises `dec_err` for one cycle, and the following byte is parsed as an opcode.
- R11: Cycles with `in_valid` low do not advance the parser, so idle gaps between the bytes of an instruction leave the decoded record unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | The byte on `in_byte` is presented this cycle |
| in_byte | input | 8 | Instruction byte |
| dec_valid | output | 1 | One-cycle strobe: decoded record is ready |
| dec_err | output | 1 | One-cycle strobe: opcode or addressing byte rejected |
| dec_class | output | 3 | Instruction class 0..5 |
| dec_is_reg | output | 1 | 1 = register operand, 0 = memory addressed by register |
| dec_dest | output | 3 | Destination register index |
| dec_subop | output | 3 | Sub-operation code |
| dec_imm | output | 32 | Assembled constant |

## Verification
The bench targets the field sources that change with the opcode. A decoder that took the destination from the wrong place would misreport the move-to-register family or the accumulator forms. A decoder that reversed byte order would return 0x0a0b0c0d in place of 0x0d0c0b0a. A decoder that left stale upper bytes in place would corrupt the 8-bit shift count after a wide constant. Rejections are driven directly, by both bad modes and undefined sub-operations. A design that failed to resynchronise afterwards would swallow the next opcode as constant data. Random idle gaps and a reset in the middle of an instruction are included to expose parsers that advance on invalid cycles or keep a partial instruction across reset.

// File: rtl/imm_dec_pkg.sv
// Shared types for the immediate-form instruction decoder.
// Assumes 3-bit register indices and byte-wide input.
package imm_dec_pkg;

    localparam int REG_W  = 3;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        CLS_GRP   = 3'd0,
        CLS_SHIFT = 3'd1,
        CLS_STORE = 3'd2,
        CLS_ACC   = 3'd3,
        CLS_MOVR  = 3'd4,
        CLS_PUSH  = 3'd5
    } op_class_t;

    typedef enum logic [1:0] {
        ST_OPCODE = 2'd0,
        ST_ADDR   = 2'd1,
        ST_IMM    = 2'd2
    } dec_state_t;

    typedef struct packed {
        logic             known;
        op_class_t        cls;
        logic             needs_addr;
        logic             wide_imm;
        logic             is_reg;
        logic [REG_W-1:0] dest;
        logic [REG_W-1:0] subop;
    } op_info_t;

endpackage

// File: rtl/imm_dec_op_table.sv
// Opcode lookup: maps one opcode byte to its class, the layout of the
// bytes that follow it, and the default record fields.
// Assumes: purely combinational; unknown opcodes return known = 0.
module imm_dec_op_table
    import imm_dec_pkg::*;
#(
    parameter logic [REG_W-1:0] ACC_IDX   = 3'd0,
    parameter logic [REG_W-1:0] STACK_IDX = 3'd4
) (
    input  logic [BYTE_W-1:0] opcode,
    output op_info_t          info
);
    localparam logic [4:0] MOVR_PREFIX = 5'b10111;

    // Decode the opcode into its class and layout.
    always_comb begin
        info = '0;
        info.cls = CLS_GRP;
        case (opcode)
            8'h81: begin info.known = 1'b1; info.cls = CLS_GRP;
                         info.needs_addr = 1'b1; info.wide_imm = 1'b1; end
            8'hc1: begin info.known = 1'b1; info.cls = CLS_SHIFT;
                         info.needs_addr = 1'b1; info.wide_imm = 1'b0; end
            8'hc7: begin info.known = 1'b1; info.cls = CLS_STORE;
                         info.needs_addr = 1'b1; info.wide_imm = 1'b1; end
            8'h25, 8'h0d, 8'h35, 8'h2d, 8'h3d: begin
                info.known    = 1'b1;
                info.cls      = CLS_ACC;
                info.wide_imm = 1'b1;
                info.is_reg   = 1'b1;
                info.dest     = ACC_IDX;
                case (opcode)
                    8'h25:   info.subop = 3'd4;
                    8'h0d:   info.subop = 3'd1;
                    8'h35:   info.subop = 3'd6;
                    8'h2d:   info.subop = 3'd5;
                    default: info.subop = 3'd7;
                endcase
            end
            8'h68: begin info.known = 1'b1; info.cls = CLS_PUSH;
                         info.wide_imm = 1'b1; info.dest = STACK_IDX; end
            default: begin
                if (opcode[7:3] == MOVR_PREFIX) begin
                    info.known    = 1'b1;
                    info.cls      = CLS_MOVR;
                    info.wide_imm = 1'b1;
                    info.is_reg   = 1'b1;
                    info.dest     = opcode[REG_W-1:0];
                end
            end
        endcase
    end
endmodule

// File: rtl/imm_dec_addr_check.sv
// Addressing-byte splitter and legality check for the class that the
// opcode selected.
// Assumes: only the register mode and the register-indirect mode are
// supported; modes that need a displacement are rejected.
module imm_dec_addr_check
    import imm_dec_pkg::*;
(
    input  op_class_t         cls,
    input  logic [BYTE_W-1:0] addr_byte,
    output logic              legal,
    output logic              is_reg,
    output logic [REG_W-1:0]  subop,
    output logic [REG_W-1:0]  dest
);
    logic [1:0] mode;
    logic       mode_ok;
    logic       subop_ok;

    // Split the byte into its fields.
    always_comb begin
        mode   = addr_byte[7:6];
        subop  = addr_byte[5:3];
        dest   = addr_byte[2:0];
        is_reg = (mode == 2'b11);
    end

    // Accept only the modes and sub-operations that this class defines.
    always_comb begin
        mode_ok = (mode == 2'b11) || (mode == 2'b00);
        case (cls)
            CLS_GRP:   subop_ok = (subop != 3'd2) && (subop != 3'd3);
            CLS_SHIFT: subop_ok = (subop == 3'd4) || (subop == 3'd5) || (subop == 3'd7);
            CLS_STORE: subop_ok = (subop == 3'd0);
            default:   subop_ok = 1'b0;
        endcase
        legal = mode_ok && subop_ok;
    end
endmodule

// File: rtl/imm_dec_imm_asm.sv
// Little-endian constant assembler: drops each accepted byte into the
// lane given by its index. The lanes are cleared at the start of every
// instruction, so a short constant comes out zero-extended.
// Assumes: clear and take are never high together.
module imm_dec_imm_asm #(
    parameter int NBYTES = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clear,
    input  logic                          take,
    input  logic [IDX_W-1:0]              idx,
    input  logic [7:0]                    byte_in,
    output logic [NBYTES*8-1:0]           merged
);
    localparam int IDX_W = (NBYTES > 1) ? $clog2(NBYTES) : 1;

    logic [NBYTES*8-1:0] acc;

    // Current value, with the byte arriving this cycle already placed.
    always_comb begin
        merged = acc;
        if (take) merged[idx*8 +: 8] = byte_in;
    end

    // Hold the partial constant across cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) acc <= '0;
        else if (take)       acc <= merged;
    end
endmodule

// File: rtl/imm_decoder.sv
// Immediate-form instruction decoder. Takes one byte per valid cycle,
// tracks opcode / addressing / constant phases, and on completion emits
// a one-cycle strobe with the decoded record. Rejections give a one-cycle
// error strobe and the parser resynchronises on the next byte.
// Assumes: synchronous active-low reset; no displacement or scale bytes.
module imm_decoder
    import imm_dec_pkg::*;
#(
    parameter int               IMM_BYTES = 4,
    parameter logic [REG_W-1:0] ACC_IDX   = 3'd0,
    parameter logic [REG_W-1:0] STACK_IDX = 3'd4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [7:0]               in_byte,
    output logic                     dec_valid,
    output logic                     dec_err,
    output logic [2:0]               dec_class,
    output logic                     dec_is_reg,
    output logic [2:0]               dec_dest,
    output logic [2:0]               dec_subop,
    output logic [IMM_BYTES*8-1:0]   dec_imm
);
    localparam int IMM_W = IMM_BYTES * 8;
    localparam int IDX_W = (IMM_BYTES > 1) ? $clog2(IMM_BYTES) : 1;
    localparam logic [IDX_W-1:0] WIDE_LAST = IDX_W'(IMM_BYTES - 1);

    dec_state_t       state;
    op_class_t        cur_cls;
    logic             cur_is_reg;
    logic [REG_W-1:0] cur_dest;
    logic [REG_W-1:0] cur_subop;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] last_idx;

    op_info_t         info;
    logic             addr_legal;
    logic             addr_is_reg;
    logic [REG_W-1:0] addr_subop;
    logic [REG_W-1:0] addr_dest;
    logic             take;
    logic             done;
    logic             reject;
    logic [IMM_W-1:0] imm_now;

    imm_dec_op_table #(
        .ACC_IDX   (ACC_IDX),
        .STACK_IDX (STACK_IDX)
    ) u_table (
        .opcode (in_byte),
        .info   (info)
    );

    imm_dec_addr_check u_addr (
        .cls       (cur_cls),
        .addr_byte (in_byte),
        .legal     (addr_legal),
        .is_reg    (addr_is_reg),
        .subop     (addr_subop),
        .dest      (addr_dest)
    );

    imm_dec_imm_asm #(
        .NBYTES (IMM_BYTES)
    ) u_imm (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (in_valid && (state == ST_OPCODE)),
        .take    (take),
        .idx     (idx),
        .byte_in (in_byte),
        .merged  (imm_now)
    );

    // Per-cycle control: constant byte taken, instruction finished, or rejected.
    always_comb begin
        take   = in_valid && (state == ST_IMM);
        done   = take && (idx == last_idx);
        reject = in_valid && (((state == ST_OPCODE) && !info.known) ||
                              ((state == ST_ADDR)   && !addr_legal));
    end

    // Phase sequencing and the fields of the instruction being parsed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_OPCODE;
            cur_cls    <= CLS_GRP;
            cur_is_reg <= 1'b0;
            cur_dest   <= '0;
            cur_subop  <= '0;
            idx        <= '0;
            last_idx   <= '0;
        end else if (in_valid) begin
            case (state)
                ST_OPCODE: begin
                    if (info.known) begin
                        cur_cls    <= info.cls;
                        cur_is_reg <= info.is_reg;
                        cur_dest   <= info.dest;
                        cur_subop  <= info.subop;
                        last_idx   <= info.wide_imm ? WIDE_LAST : '0;
                        idx        <= '0;
                        state      <= info.needs_addr ? ST_ADDR : ST_IMM;
                    end
                end
                ST_ADDR: begin
                    if (addr_legal) begin
                        cur_is_reg <= addr_is_reg;
                        cur_dest   <= addr_dest;
                        cur_subop  <= addr_subop;
                        state      <= ST_IMM;
                    end else begin
                        state      <= ST_OPCODE;
                    end
                end
                ST_IMM: begin
                    if (idx == last_idx) state <= ST_OPCODE;
                    else                 idx   <= idx + 1'b1;
                end
                default: state <= ST_OPCODE;
            endcase
        end
    end

    // Output record and the two strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid  <= 1'b0;
            dec_err    <= 1'b0;
            dec_class  <= '0;
            dec_is_reg <= 1'b0;
            dec_dest   <= '0;
            dec_subop  <= '0;
            dec_imm    <= '0;
        end else begin
            dec_valid <= done;
            dec_err   <= reject;
            if (done) begin
                dec_class  <= cur_cls;
                dec_is_reg <= cur_is_reg;
                dec_dest   <= cur_dest;
                dec_subop  <= cur_subop;
                dec_imm    <= imm_now;
            end
        end
    end
endmodule

// File: rtl/imm_decoder_chk.sv
// Property checker for imm_decoder, attached with bind below.
// Assumes default parameters (32-bit constant, accumulator 0, stack 4).
module imm_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        dec_valid,
    input logic        dec_err,
    input logic [2:0]  dec_class,
    input logic        dec_is_reg,
    input logic [2:0]  dec_dest,
    input logic [2:0]  dec_subop,
    input logic [31:0] dec_imm
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!dec_valid && !dec_err));                                   // R1

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> !dec_valid);                                              // R8

    AST_VALID_NOT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        !(dec_valid && dec_err));                                               // R9

    AST_MOVR_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_class == 3'd4) |-> (dec_is_reg && dec_subop == 3'd0)); // R3

    AST_SHIFT_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_class == 3'd1) |-> (dec_imm[31:8] == 24'd0));         // R5

    AST_ACC_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_class == 3'd3) |-> (dec_is_reg && dec_dest == 3'd0)); // R6

    AST_PUSH_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_class == 3'd5) |-> (!dec_is_reg && dec_dest == 3'd4)); // R7

    AST_STORE_SUBOP: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_class == 3'd2) |-> (dec_subop == 3'd0));              // R10

    AST_NEEDS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid || dec_err) |-> $past(in_valid));                            // R11
endmodule

bind imm_decoder imm_decoder_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .dec_valid  (dec_valid),
    .dec_err    (dec_err),
    .dec_class  (dec_class),
    .dec_is_reg (dec_is_reg),
    .dec_dest   (dec_dest),
    .dec_subop  (dec_subop),
    .dec_imm    (dec_imm)
);

// File: tb/imm_decoder_bench.sv
// Bench for imm_decoder: directed corner cases plus seeded random
// instruction streams, with expected records from bench functions.
module imm_decoder_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        dec_valid, dec_err, dec_is_reg;
    logic [2:0]  dec_class, dec_dest, dec_subop;
    logic [31:0] dec_imm;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    imm_decoder u_imm_decoder (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .dec_valid(dec_valid), .dec_err(dec_err), .dec_class(dec_class),
        .dec_is_reg(dec_is_reg), .dec_dest(dec_dest), .dec_subop(dec_subop),
        .dec_imm(dec_imm)
    );

    // ---- reference functions from the requirements ----
    function automatic bit f_known(input logic [7:0] op);
        return (op == 8'h81) || (op == 8'hc1) || (op == 8'hc7) || (op == 8'h25) ||
               (op == 8'h0d) || (op == 8'h35) || (op == 8'h2d) || (op == 8'h3d) ||
               (op == 8'h68) || (op[7:3] == 5'b10111);
    endfunction

    function automatic bit f_has_addr(input logic [7:0] op);
        return (op == 8'h81) || (op == 8'hc1) || (op == 8'hc7);
    endfunction

    function automatic int f_imm_len(input logic [7:0] op);
        return (op == 8'hc1) ? 1 : 4;
    endfunction

    function automatic logic [2:0] f_class(input logic [7:0] op);
        case (op)
            8'h81: return 3'd0;
            8'hc1: return 3'd1;
            8'hc7: return 3'd2;
            8'h68: return 3'd5;
            8'h25, 8'h0d, 8'h35, 8'h2d, 8'h3d: return 3'd3;
            default: return 3'd4;
        endcase
    endfunction

    function automatic bit f_addr_ok(input logic [7:0] op, input logic [7:0] am);
        logic [2:0] s;
        s = am[5:3];
        if (am[7:6] == 2'b01 || am[7:6] == 2'b10) return 1'b0;
        if (op == 8'h81) return (s != 3'd2) && (s != 3'd3);
        if (op == 8'hc1) return (s == 3'd4) || (s == 3'd5) || (s == 3'd7);
        return (s == 3'd0);
    endfunction

    function automatic logic [2:0] f_acc_sub(input logic [7:0] op);
        case (op)
            8'h25: return 3'd4;
            8'h0d: return 3'd1;
            8'h35: return 3'd6;
            8'h2d: return 3'd5;
            default: return 3'd7;
        endcase
    endfunction

    // ---- checking and driving ----
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b, input int maxgap);
        int g;
        g = (maxgap > 0) ? int'($urandom_range(maxgap, 0)) : 0;
        repeat (g) @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        @(negedge clk);
        in_valid = 1'b0;
        in_byte  = $urandom();
    endtask

    task automatic do_instr(input logic [7:0] op, input logic [7:0] am,
                            input logic [31:0] imm, input int maxgap);
        logic [2:0]  e_cls, e_dest, e_sub;
        logic        e_reg;
        logic [31:0] e_imm;
        int          n;
        send(op, maxgap);
        if (!f_known(op)) begin
            chk("R9 err on unknown opcode", {31'd0, dec_err}, 32'd1);
            chk("R9 no valid on unknown opcode", {31'd0, dec_valid}, 32'd0);
            return;
        end
        chk("R9 no err on known opcode", {31'd0, dec_err}, 32'd0);
        e_cls = f_class(op);
        if (f_has_addr(op)) begin
            send(am, maxgap);
            if (!f_addr_ok(op, am)) begin
                chk("R10 err on bad addressing byte", {31'd0, dec_err}, 32'd1);
                return;
            end
            chk("R10 no err on legal addressing byte", {31'd0, dec_err}, 32'd0);
            e_reg  = (am[7:6] == 2'b11);
            e_sub  = am[5:3];
            e_dest = am[2:0];
        end else if (e_cls == 3'd3) begin
            e_reg = 1'b1; e_dest = 3'd0; e_sub = f_acc_sub(op);
        end else if (e_cls == 3'd5) begin
            e_reg = 1'b0; e_dest = 3'd4; e_sub = 3'd0;
        end else begin
            e_reg = 1'b1; e_dest = op[2:0]; e_sub = 3'd0;
        end
        n = f_imm_len(op);
        e_imm = (n == 1) ? {24'd0, imm[7:0]} : imm;
        for (int i = 0; i < n; i++) begin
            send(imm[i*8 +: 8], maxgap);
            if (i < n - 1) chk("R8 no early valid", {31'd0, dec_valid}, 32'd0);
        end
        chk("R8 valid after last byte", {31'd0, dec_valid}, 32'd1);
        chk("R3 R4 R6 R7 class", {29'd0, dec_class}, {29'd0, e_cls});
        chk("R4 R6 R7 register mode", {31'd0, dec_is_reg}, {31'd0, e_reg});
        chk("R3 R4 R6 R7 destination", {29'd0, dec_dest}, {29'd0, e_dest});
        chk("R4 R5 R6 sub-operation", {29'd0, dec_subop}, {29'd0, e_sub});
        chk("R2 R5 constant", dec_imm, e_imm);
    endtask

    localparam logic [7:0] OPS [0:17] = '{8'h81, 8'hc1, 8'hc7, 8'h25, 8'h0d, 8'h35,
        8'h2d, 8'h3d, 8'h68, 8'hb8, 8'hb9, 8'hba, 8'hbb, 8'hbc, 8'hbd, 8'hbe, 8'hbf, 8'h81};

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        logic [31:0] held;
        void'($urandom(32'h5eed_1234));
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 valid low in reset", {31'd0, dec_valid}, 32'd0);
        chk("R1 err low in reset", {31'd0, dec_err}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R4: register-mode add, little-endian constant
        do_instr(8'h81, 8'hc3, 32'h0d0c0b0a, 0);
        // R4: memory-mode and
        do_instr(8'h81, 8'h23, 32'h0d0c0b0a, 0);
        // R4: store with memory mode
        do_instr(8'hc7, 8'h03, 32'h0d0c0b0a, 0);
        // R5: arithmetic right shift by one, after a wide constant left ff in upper lanes
        do_instr(8'hb8, 8'h00, 32'hffffffff, 0);
        do_instr(8'hc1, 8'hfb, 32'hffffff01, 0);
        // R6: all accumulator forms
        do_instr(8'h25, 8'h00, 32'h0d0c0b0a, 0);
        do_instr(8'h0d, 8'h00, 32'h0d0c0b0a, 0);
        do_instr(8'h35, 8'h00, 32'h0d0c0b0a, 0);
        do_instr(8'h2d, 8'h00, 32'h0d0c0b0a, 0);
        do_instr(8'h3d, 8'h00, 32'h0d0c0b07, 0);
        // R7: push
        do_instr(8'h68, 8'h00, 32'h000000af, 0);
        // R3: every move-to-register opcode
        for (int r = 0; r < 8; r++) do_instr(8'hb8 | 8'(r), 8'h00, 32'h1000 + 32'(r), 0);

        // R8: record held, strobe dropped
        held = dec_imm;
        @(negedge clk);
        chk("R8 strobe is one cycle", {31'd0, dec_valid}, 32'd0);
        chk("R8 record held", dec_imm, held);

        // R9 then resync
        do_instr(8'h90, 8'h00, 32'h0, 0);
        do_instr(8'hbb, 8'h00, 32'hcafe0001, 0);
        // R10: rejected addressing bytes, each followed by a good instruction
        do_instr(8'h81, 8'h43, 32'h0, 0);
        do_instr(8'h25, 8'h00, 32'h11223344, 0);
        do_instr(8'h81, 8'h93, 32'h0, 0);
        do_instr(8'hc7, 8'hc8, 32'h0, 0);
        do_instr(8'hc1, 8'hf3, 32'h0, 0);
        do_instr(8'hc7, 8'hbb, 32'h0, 0);
        do_instr(8'hbe, 8'h00, 32'h55667788, 0);

        // R11: long idle gap in the middle of an instruction
        send(8'hba, 0);
        repeat (12) @(negedge clk);
        chk("R11 no progress while idle", {31'd0, dec_valid}, 32'd0);
        for (int i = 0; i < 4; i++) send(8'h10 + 8'(i), 0);
        chk("R11 valid after gap", {31'd0, dec_valid}, 32'd1);
        chk("R11 constant after gap", dec_imm, 32'h13121110);

        // R1: reset partway through an instruction
        send(8'h81, 0);
        send(8'hc0, 0);
        send(8'h01, 0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 valid low after mid reset", {31'd0, dec_valid}, 32'd0);
        do_instr(8'h2d, 8'h00, 32'h00000001, 0);

        // random streams with idle gaps
        for (int k = 0; k < 400; k++) begin
            logic [7:0] op;
            op = ($urandom_range(9, 0) == 0) ? 8'($urandom()) : OPS[$urandom_range(17, 0)];
            do_instr(op, 8'($urandom()), $urandom(), 2);
        end
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule